// File: doc/BRIEF.md
# Folded Constant-Geometry Radix-2 FFT Core

This core computes the forward discrete Fourier transform of a block of `N` complex fixed-point samples. It has one column of hardware. The column reads its operand pairs through a perfect-shuffle wiring, holds `N/2` radix-2 butterflies, and ends in a twiddle-factor multiply on the difference outputs. Every stage of a constant-geometry radix-2 decomposition has the same structure, so this one column is reused for all `log2(N)` passes. A single working register carries each pass's result back to the column's input.

Samples enter one per cycle, in natural index order, through a valid/ready handshake. The working register's write port has two sources. While a block is loading it takes the incoming sample, and during the passes it takes the column's result. The passes then run on consecutive cycles, one pass per cycle. The transform is then streamed out one sample per accepted cycle, in bit-reversed bin order.

Each pass halves its results with rounding, so the delivered spectrum is the true DFT divided by `N`. Full-scale inputs therefore cannot wrap. Twiddle factors are signed fixed-point cosine/sine pairs with `W-1` fraction bits. They are computed when the design is elaborated, and the selected index depends on the pass number and the butterfly position.

Top module: `cg_fft_core`

## Requirements
- R1: After reset is released, `in_ready` is 1 and `out_valid` is 0, whatever phase the core was in when reset was applied.
- R2: `in_ready` and `out_valid` are never high in the same cycle. `in_ready` falls in the cycle after the N-th sample of a block is accepted and stays low through the passes and the output phase.
- R3: `out_valid` first rises exactly `log2(N)` clock cycles after the edge that accepts the last input sample. That is 4 cycles for N=16.
- R4: Each delivered value equals (1/N)·Σ x_k·e^(−j2πkm/N) for its bin m, within ±4 LSB on each of the real and imaginary parts. Input sample k is the k-th sample accepted in the block.
- R5: The m-th delivered sample (counting from 0) holds bin bitrev(m), the `log2(N)`-bit reversal of m. For N=16, bin 1 appears at delivery position 8.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_re`/`out_im` do not change.
- R7: Exactly N samples are delivered per block. In the cycle after the N-th output is accepted, `out_valid` is 0 and `in_ready` is 1.
- R8: `in_valid` and the input data have no effect while `in_ready` is low. A block loaded next to such stimulus still produces the spectrum of the samples that were actually accepted.
- R9: A full-scale constant input of −32768 or +32767 on the real part yields exactly that value at delivery position 0 and exactly 0 everywhere else, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core accepts a sample this cycle |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample this cycle |
| out_re | output | W | Output real part, two's complement |
| out_im | output | W | Output imaginary part, two's complement |

## Verification
Each pattern checks a different part of the core. Impulses at index 0 and at index 5 give a flat or linearly rotating spectrum, which checks the twiddle selection across every pass and every butterfly position. A DC vector and a real cosine put energy in one or two bins. A complex exponential at bin 1 must land only at delivery position 8, which separates a correct bit-reversed order from a natural or shuffled one. A ramp with alternating imaginary part fills every bin. Full-scale DC vectors, compared with zero tolerance, expose any wrap or bias in the per-pass rounding. Stalled output cycles and stray input strobes during the passes and the output phase check the handshake rules and the protection of the working register.

// File: rtl/cg_fft_pkg.sv
`timescale 1ns/1ps
// Package cg_fft_pkg
// Shared phase encoding and elaboration-time trigonometry for the folded FFT.
// Assumes the angle fixed point (30 fraction bits) is finer than any sample width used.
package cg_fft_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_CALC  = 2'd1,
        ST_DRAIN = 2'd2
    } phase_t;

    localparam int     ANG_FRAC = 30;
    localparam longint PI_FX    = 64'sd3373259426;   // pi with 30 fraction bits

    // cos or sin of 2*pi*idx/npts for 0 <= idx < npts/2, 30 fraction bits (Taylor series)
    function automatic longint trig_fx(input int idx, input int npts, input bit want_sin);
        longint th;
        longint t2;
        longint term;
        longint acc;
        bit     neg;
        th  = (PI_FX * 2 * idx) / npts;
        neg = 1'b0;
        if (th > PI_FX / 2) begin
            th  = PI_FX - th;
            neg = !want_sin;
        end
        t2   = (th * th) >>> ANG_FRAC;
        term = want_sin ? th : (64'sd1 <<< ANG_FRAC);
        acc  = term;
        for (int k = 1; k <= 8; k++) begin
            if (want_sin) term = -((term * t2) >>> ANG_FRAC) / ((2 * k) * (2 * k + 1));
            else          term = -((term * t2) >>> ANG_FRAC) / ((2 * k - 1) * (2 * k));
            acc = acc + term;
        end
        return neg ? -acc : acc;
    endfunction

    // Round a 30-fraction-bit value to frac_bits fraction bits and clamp to a signed word
    function automatic longint to_q(input longint v, input int frac_bits);
        longint r;
        longint hi;
        r  = (v + (64'sd1 <<< (ANG_FRAC - frac_bits - 1))) >>> (ANG_FRAC - frac_bits);
        hi = (64'sd1 <<< frac_bits) - 1;
        if (r > hi)      r = hi;
        if (r < -hi - 1) r = -hi - 1;
        return r;
    endfunction

endpackage

// File: rtl/cg_twiddle_rom.sv
`timescale 1ns/1ps
// Module cg_twiddle_rom
// Holds N/2 twiddle factors W_N^e = cos(2*pi*e/N) - j*sin(2*pi*e/N) in signed
// fixed point with W-1 fraction bits, computed at elaboration. For every butterfly
// position j it selects exponent (j >> pass) << pass, as the constant-geometry
// decimation-in-frequency order needs. Assumes N is a power of two, N >= 4.
module cg_twiddle_rom #(
    parameter int N      = 16,
    parameter int W      = 16,
    parameter int PASS_W = 3
) (
    input  logic [PASS_W-1:0]       pass,
    output logic [N/2-1:0][W-1:0]   tw_re,
    output logic [N/2-1:0][W-1:0]   tw_im
);
    localparam int HALF = N / 2;
    localparam int HW   = $clog2(HALF);

    logic [HALF-1:0][W-1:0] rom_re;
    logic [HALF-1:0][W-1:0] rom_im;

    // Constant table: one cos/sin pair per exponent
    for (genvar e = 0; e < HALF; e++) begin : g_entry
        localparam longint C_FX = cg_fft_pkg::to_q(cg_fft_pkg::trig_fx(e, N, 1'b0), W - 1);
        localparam longint S_FX = -cg_fft_pkg::to_q(cg_fft_pkg::trig_fx(e, N, 1'b1), W - 1);
        assign rom_re[e] = C_FX[W-1:0];
        assign rom_im[e] = S_FX[W-1:0];
    end

    // Per-butterfly exponent select: clear the low 'pass' bits of the position
    for (genvar j = 0; j < HALF; j++) begin : g_sel
        logic [HW-1:0] idx;
        assign idx      = (HW'(j) >> pass) << pass;
        assign tw_re[j] = rom_re[idx];
        assign tw_im[j] = rom_im[idx];
    end

endmodule

// File: rtl/cg_butterfly.sv
`timescale 1ns/1ps
// Module cg_butterfly
// One radix-2 butterfly with the twiddle on the difference branch.
// s = round((a + b) / 2), d = sat(round((a - b) * tw / 2)).
// The twiddle has W-1 fraction bits. The sum branch cannot overflow. The product
// branch saturates, which only happens for near-full-scale complex inputs.
module cg_butterfly #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a_re,
    input  logic signed [W-1:0] a_im,
    input  logic signed [W-1:0] b_re,
    input  logic signed [W-1:0] b_im,
    input  logic signed [W-1:0] tw_re,
    input  logic signed [W-1:0] tw_im,
    output logic signed [W-1:0] s_re,
    output logic signed [W-1:0] s_im,
    output logic signed [W-1:0] d_re,
    output logic signed [W-1:0] d_im
);
    localparam int MW = 2 * W + 3;

    logic signed [W+1:0]  sum_re, sum_im;
    logic signed [MW-1:0] dif_re, dif_im;
    logic signed [MW-1:0] prd_re, prd_im;
    logic signed [MW-1:0] shr_re, shr_im;

    // Clamp a wide product back into a W-bit signed word
    function automatic logic [W-1:0] clip(input logic [MW-1:0] v);
        if (v[MW-1:W-1] != {(MW - W + 1){v[W-1]}})
            return v[MW-1] ? {1'b1, {(W - 1){1'b0}}} : {1'b0, {(W - 1){1'b1}}};
        return v[W-1:0];
    endfunction

    // Sum branch: add, then halve with round-half-up (floor of (a+b+1)/2)
    always_comb begin
        sum_re = (W + 2)'(a_re) + (W + 2)'(b_re) + (W + 2)'(1);
        sum_im = (W + 2)'(a_im) + (W + 2)'(b_im) + (W + 2)'(1);
        s_re   = sum_re[W:1];
        s_im   = sum_im[W:1];
    end

    // Difference branch: complex multiply by the twiddle, round, halve, saturate
    always_comb begin
        dif_re = MW'(a_re) - MW'(b_re);
        dif_im = MW'(a_im) - MW'(b_im);
        prd_re = dif_re * MW'(tw_re) - dif_im * MW'(tw_im) + (MW'(1) <<< (W - 1));
        prd_im = dif_re * MW'(tw_im) + dif_im * MW'(tw_re) + (MW'(1) <<< (W - 1));
        shr_re = prd_re >>> W;
        shr_im = prd_im >>> W;
        d_re   = clip(shr_re);
        d_im   = clip(shr_im);
    end

endmodule

// File: rtl/cg_stage.sv
`timescale 1ns/1ps
// Module cg_stage
// The single reusable stage column. The stride wiring feeds butterfly j with
// elements j and j+N/2. This is the perfect shuffle: for N=8 the pairs are
// (0,4),(1,5),(2,6),(3,7). Butterfly j writes its sum to slot 2j and its
// twiddled difference to slot 2j+1. Each element packs {re, im}.
module cg_stage #(
    parameter int N      = 16,
    parameter int W      = 16,
    parameter int PASS_W = 3
) (
    input  logic [PASS_W-1:0]        pass,
    input  logic [N-1:0][2*W-1:0]    x,
    output logic [N-1:0][2*W-1:0]    y
);
    localparam int HALF = N / 2;

    logic [HALF-1:0][W-1:0] tw_re;
    logic [HALF-1:0][W-1:0] tw_im;

    cg_twiddle_rom #(.N(N), .W(W), .PASS_W(PASS_W)) u_rom (
        .pass  (pass),
        .tw_re (tw_re),
        .tw_im (tw_im)
    );

    // Bank of N/2 butterflies on the shuffled pairs
    for (genvar j = 0; j < HALF; j++) begin : g_bf
        cg_butterfly #(.W(W)) u_bf (
            .a_re  (x[j][2*W-1:W]),
            .a_im  (x[j][W-1:0]),
            .b_re  (x[j+HALF][2*W-1:W]),
            .b_im  (x[j+HALF][W-1:0]),
            .tw_re (tw_re[j]),
            .tw_im (tw_im[j]),
            .s_re  (y[2*j][2*W-1:W]),
            .s_im  (y[2*j][W-1:0]),
            .d_re  (y[2*j+1][2*W-1:W]),
            .d_im  (y[2*j+1][W-1:0])
        );
    end

endmodule

// File: rtl/cg_fft_core.sv
`timescale 1ns/1ps
// Module cg_fft_core
// Folded constant-geometry radix-2 FFT. It loads N samples serially, runs
// log2(N) passes through one stage column (one pass per cycle, fed back through
// the working register), then streams the N results out in bit-reversed bin
// order. Results are the DFT scaled by 1/N. Assumes N is a power of two with
// N >= 4 and W <= 30.
module cg_fft_core #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                out_valid,
    input  logic                out_ready,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    import cg_fft_pkg::*;

    localparam int LOGN   = $clog2(N);
    localparam int PASS_W = $clog2(LOGN + 1);
    localparam logic [LOGN-1:0]   LAST_IDX  = LOGN'(N - 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(LOGN - 1);

    phase_t                  phase;
    logic [LOGN-1:0]         cnt;
    logic [PASS_W-1:0]       pass;
    logic [N-1:0][2*W-1:0]   work;
    logic [N-1:0][2*W-1:0]   stage_y;
    logic                    in_fire;
    logic                    out_fire;

    assign in_ready  = (phase == ST_LOAD);
    assign out_valid = (phase == ST_DRAIN);
    assign in_fire   = in_ready && in_valid;
    assign out_fire  = out_valid && out_ready;
    assign out_re    = work[cnt][2*W-1:W];
    assign out_im    = work[cnt][W-1:0];

    cg_stage #(.N(N), .W(W), .PASS_W(PASS_W)) u_stage (
        .pass (pass),
        .x    (work),
        .y    (stage_y)
    );

    // Phase sequencer: sample counter for load/drain, pass counter for compute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_LOAD;
            cnt   <= '0;
            pass  <= '0;
        end else begin
            unique case (phase)
                ST_LOAD: if (in_fire) begin
                    if (cnt == LAST_IDX) begin
                        cnt   <= '0;
                        pass  <= '0;
                        phase <= ST_CALC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CALC: begin
                    if (pass == LAST_PASS) begin
                        pass  <= '0;
                        phase <= ST_DRAIN;
                    end else begin
                        pass <= pass + 1'b1;
                    end
                end
                ST_DRAIN: if (out_fire) begin
                    if (cnt == LAST_IDX) begin
                        cnt   <= '0;
                        phase <= ST_LOAD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= ST_LOAD;
            endcase
        end
    end

    // Working register write port: the bypass selects a new sample in load, the stage result in compute
    always_ff @(posedge clk) begin
        if (in_fire) begin
            work[cnt] <= {in_re, in_im};
        end else if (phase == ST_CALC) begin
            work <= stage_y;
        end
    end

    // Handshake and sequencing properties
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_ready && !out_valid));

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_last_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && cnt == LAST_IDX) |=> !in_ready);

    p_pass_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_CALC && pass != LAST_PASS) |=> (phase == ST_CALC && pass == $past(pass) + 1'b1));

    p_pass_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_CALC && pass == LAST_PASS) |=> out_valid);

    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    p_drain_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && cnt == LAST_IDX) |=> (in_ready && !out_valid));

    p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && phase == ST_DRAIN) |=> $stable(work));

endmodule

// File: tb/cg_fft_core_bench.sv
`timescale 1ns/1ps
module cg_fft_core_bench;
    localparam int  N    = 16;
    localparam int  W    = 16;
    localparam int  LOGN = 4;
    localparam real PI   = 3.14159265358979323846;
    localparam int  NPAT = 6;

    // Stimulus table: kind (0 impulse, 1 DC, 2 complex exponential, 3 real cosine, 4 ramp),
    // amplitude, bin/position, stall output, strobe input while busy
    localparam int PAT_KIND  [NPAT] = '{0,     0,     1,    2,    3,     4};
    localparam int PAT_AMP   [NPAT] = '{20000, 12000, 9000, 8000, 12000, 16000};
    localparam int PAT_BIN   [NPAT] = '{0,     5,     0,    1,    3,     0};
    localparam bit PAT_STALL [NPAT] = '{0,     0,     0,    0,    1,     1};
    localparam bit PAT_NOISY [NPAT] = '{0,     1,     0,    0,    0,     1};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic signed [W-1:0] in_re = '0;
    logic signed [W-1:0] in_im = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic signed [W-1:0] out_re;
    logic signed [W-1:0] out_im;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  stim_re [N];
    int  stim_im [N];
    int  exp_re  [N];
    int  exp_im  [N];

    always #4 clk = ~clk;

    cg_fft_core #(.N(N), .W(W)) u_cg_fft_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int bitrev(input int m);
        int r = 0;
        for (int b = 0; b < LOGN; b++) r |= ((m >> b) & 1) << (LOGN - 1 - b);
        return r;
    endfunction

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Build the stimulus for one pattern and its scaled reference spectrum
    task automatic build(input int kind, input int amp, input int bin);
        for (int k = 0; k < N; k++) begin
            real ph = 2.0 * PI * real'(bin * k) / real'(N);
            case (kind)
                0: begin stim_re[k] = (k == bin) ? amp : 0; stim_im[k] = (k == bin) ? -amp / 3 : 0; end
                1: begin stim_re[k] = amp; stim_im[k] = 0; end
                2: begin stim_re[k] = rnd(real'(amp) * $cos(ph)); stim_im[k] = rnd(real'(amp) * $sin(ph)); end
                3: begin stim_re[k] = rnd(real'(amp) * $cos(ph)); stim_im[k] = 0; end
                default: begin stim_re[k] = (amp * (k - N / 2)) / N; stim_im[k] = (k % 2 == 1) ? amp / 4 : -amp / 4; end
            endcase
        end
        for (int m = 0; m < N; m++) begin
            real sr = 0.0;
            real si = 0.0;
            for (int k = 0; k < N; k++) begin
                real a = -2.0 * PI * real'(k * m) / real'(N);
                sr += real'(stim_re[k]) * $cos(a) - real'(stim_im[k]) * $sin(a);
                si += real'(stim_re[k]) * $sin(a) + real'(stim_im[k]) * $cos(a);
            end
            exp_re[m] = rnd(sr / real'(N));
            exp_im[m] = rnd(si / real'(N));
        end
    endtask

    // Load one block, then measure the latency to the first output (R2, R3, R8)
    task automatic send_block(input bit noisy);
        int  lat = 0;
        bit  seen = 1'b0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re    = W'(stim_re[k]);
            in_im    = W'(stim_im[k]);
            chk(in_ready, "R2 ready during load", int'(in_ready), 1);
            @(posedge clk);
        end
        for (int i = 0; i < 3 * LOGN + 4; i++) begin
            @(negedge clk);
            in_valid = noisy;             // R8 stray strobes while busy
            in_re    = W'(16'sh5A5A + i);
            in_im    = W'(-1234 - i);
            if (out_valid) begin
                seen = 1'b1;
                break;
            end
            chk(!in_ready, "R2 ready low while computing", int'(in_ready), 0);
            @(posedge clk);
            lat++;
        end
        chk(seen && lat == LOGN, "R3 latency to first output", lat, LOGN);
    endtask

    // Drain one block and compare against the reference (R4, R5, R6, R7, R9)
    task automatic recv_block(input bit stall, input bit noisy, input int tol, input string tag,
                              input int r5_bin, input int r5_amp);
        for (int m = 0; m < N; m++) begin
            int bin = bitrev(m);
            int gr;
            int gi;
            if (stall && (m % 3 == 1)) begin
                logic signed [W-1:0] hr = out_re;
                logic signed [W-1:0] hi = out_im;
                out_ready = 1'b0;
                @(negedge clk);
                chk(out_valid && out_re == hr && out_im == hi, "R6 hold under back-pressure",
                    int'(out_re), int'(hr));
            end
            out_ready = 1'b1;
            chk(out_valid, "R7 output present for each of N samples", int'(out_valid), 1);
            chk(!in_ready, "R2 ready low while draining", int'(in_ready), 0);
            gr = int'(out_re);
            gi = int'(out_im);
            chk(absv(gr - exp_re[bin]) <= tol, tag, gr, exp_re[bin]);
            chk(absv(gi - exp_im[bin]) <= tol, tag, gi, exp_im[bin]);
            if (r5_bin >= 0 && m == bitrev(r5_bin))
                chk(absv(gr - r5_amp) <= 4, "R5 bin 1 at delivery position 8", gr, r5_amp);
            @(posedge clk);
            @(negedge clk);
            in_valid = noisy;
            in_re    = W'(-777 + m);
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        chk(in_ready && !out_valid, "R7 back to load after N outputs", int'(in_ready), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready,   "R1 in_ready after reset",  int'(in_ready), 1);
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);

        // Table walk: R4 on every pattern, R5 on the bin-1 exponential, R6/R8 where flagged
        for (int p = 0; p < NPAT; p++) begin
            build(PAT_KIND[p], PAT_AMP[p], PAT_BIN[p]);
            send_block(PAT_NOISY[p]);
            recv_block(PAT_STALL[p], PAT_NOISY[p], 4,
                       PAT_NOISY[p] ? "R8 spectrum with stray input" : "R4 spectrum value",
                       (PAT_KIND[p] == 2) ? PAT_BIN[p] : -1, PAT_AMP[p]);
        end

        // R9: full-scale DC, exact
        build(1, -32768, 0);
        send_block(1'b0);
        recv_block(1'b0, 1'b0, 0, "R9 full-scale negative DC", -1, 0);
        build(1, 32767, 0);
        send_block(1'b0);
        recv_block(1'b0, 1'b0, 0, "R9 full-scale positive DC", -1, 0);

        // R1: reset in the middle of draining, then a clean block
        build(0, 20000, 0);
        send_block(1'b0);
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready,   "R1 in_ready after mid-block reset",  int'(in_ready), 1);
        chk(!out_valid, "R1 out_valid after mid-block reset", int'(out_valid), 0);
        build(2, 8000, 1);
        send_block(1'b0);
        recv_block(1'b0, 1'b0, 4, "R4 spectrum after reset", 1, 8000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule